// File: doc/BRIEF.md
# Palette-Indexed Image Display Pipeline

This block turns the pixel coordinates of a 640x480 video timing generator into colour for a VGA port. Two pictures of 640 by 360 pixels sit in an external block memory, each pixel stored as a 6-bit palette index. For every pixel the block forms the linear read address (line times the screen width, plus the column) and picks the memory bank of the current picture. It then passes the returned index through one of four palettes and drives 4-bit red, green and blue channels.

The picture is chosen by `img_sel`. That input is taken only at the first pixel of a frame (column 0, line 0), so a frame never shows parts of both pictures. A 2-bit switch code `pal_sel` picks the palette for each pixel. Code 00 is the default: each picture is shown with its own palette. Codes 01 and 10 force one fixed palette onto either picture. Code 11 is a grey ramp.

The memory read and the palette lookup take two clock cycles in total. The active-video flag and both sync signals are delayed by the same two cycles, so colour and sync reach the port together. Lines 360 to 479 of the visible area lie below the picture: nothing is fetched for them and they show black.

Top module: `idx_image_display`

## Requirements
- R1: When `active` is high, `line` < 360 and `col` < 640, `mem_en` is high in the same cycle and `mem_addr` equals line*640 + col.
- R2: When `line` >= 360 or `active` is low, `mem_en` is low. A pixel that is active but lies on lines 360 to 479 gives red, green and blue of 0 two cycles later.
- R3: Whenever `active_out` is low, `red`, `green` and `blue` are all 0.
- R4: `active_out`, `hsync_out` and `vsync_out` equal `active`, `hsync_in` and `vsync_in` from two clock edges earlier. The colour of a pixel appears in the same cycle as its delayed `active_out`.
- R5: With `pal_sel` = 00, each picture uses its own palette. For bank 0 with index i, red = {i[5:4],i[5:4]}, green = {i[3:2],i[3:2]} and blue = {i[1:0],i[1:0]}. For bank 1, red = {i[1:0],i[1:0]}, green = {i[3:2],i[3:2]} and blue = {i[5:4],i[5:4]}.
- R6: With `pal_sel` = 01, the bank-0 palette of R5 is applied to whichever picture is shown. With `pal_sel` = 10, the bank-1 palette of R5 is applied to whichever picture is shown.
- R7: With `pal_sel` = 11, all three channels equal i[5:2].
- R8: `mem_bank` takes the value of `img_sel` in the cycle where `col` = 0 and `line` = 0. In every other cycle it keeps its previous value, whatever `img_sel` does.
- R9: While `rst` is high, and in the cycle after it falls, all outputs that are registered read 0, and `mem_bank` holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| col | input | 10 | Current pixel column from the timing generator |
| line | input | 10 | Current pixel line from the timing generator |
| active | input | 1 | Visible-area flag from the timing generator |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| img_sel | input | 1 | Picture choice, taken at the frame origin |
| pal_sel | input | 2 | Palette switch code |
| mem_en | output | 1 | Read enable to the bitmap memory |
| mem_bank | output | 1 | Picture bank to read |
| mem_addr | output | 18 | Linear pixel address within the bank |
| mem_rdata | input | 6 | Palette index, valid one cycle after the read |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |
| active_out | output | 1 | Active flag aligned to colour |
| hsync_out | output | 1 | Horizontal sync aligned to colour |
| vsync_out | output | 1 | Vertical sync aligned to colour |

## Verification
The bench drives lines 359 and 360 and columns 639 and 640, where an off-by-one bound would fetch a line below the picture or wrap the address into the next line. It changes `img_sel` in the middle of a frame and then again at the origin. A design that samples it too freely would switch banks partway through a picture, and one that never samples it would stay on the old picture. Each of the four palette codes is applied to both banks, so swapped channels or a default that ignores the bank show up as wrong colours. Random coordinates, with active video high and low and sync toggling, expose any colour that is one cycle away from its sync, and any blanking that leaks a colour.

// File: rtl/idx_image_display_pkg.sv
package idx_image_display_pkg;

    localparam int IDX_W   = 6;
    localparam int CH_W    = 4;
    localparam int COORD_W = 10;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        PAL_OWN   = 2'b00,
        PAL_WARM  = 2'b01,
        PAL_COOL  = 2'b10,
        PAL_GREY  = 2'b11
    } pal_code_e;

    function automatic logic [CH_W-1:0] widen2(input logic [1:0] v);
        return {v, v};
    endfunction

    function automatic rgb_t warm_map(input logic [IDX_W-1:0] i);
        rgb_t c;
        c.r = widen2(i[5:4]);
        c.g = widen2(i[3:2]);
        c.b = widen2(i[1:0]);
        return c;
    endfunction

    function automatic rgb_t cool_map(input logic [IDX_W-1:0] i);
        rgb_t c;
        c.r = widen2(i[1:0]);
        c.g = widen2(i[3:2]);
        c.b = widen2(i[5:4]);
        return c;
    endfunction

    function automatic rgb_t pal_color(input pal_code_e code, input logic bank,
                                       input logic [IDX_W-1:0] i);
        rgb_t c;
        case (code)
            PAL_OWN:  c = bank ? cool_map(i) : warm_map(i);
            PAL_WARM: c = warm_map(i);
            PAL_COOL: c = cool_map(i);
            default:  c = '{r: i[5:2], g: i[5:2], b: i[5:2]};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/idx_image_addr_gen.sv
module idx_image_addr_gen
    import idx_image_display_pkg::*;
#(
    parameter int IMG_W    = 640,
    parameter int IMG_H    = 360,
    parameter int STRIDE   = 640,
    parameter int ADDR_W   = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] line,
    input  logic               active,
    input  logic               img_sel,
    output logic               fetch,
    output logic               bank,
    output logic [ADDR_W-1:0]  addr
);
    logic bank_held;
    logic at_origin;

    assign at_origin = (col == '0) && (line == '0);
    assign bank      = at_origin ? img_sel : bank_held;
    assign fetch     = active && (int'(line) < IMG_H) && (int'(col) < IMG_W);

    always_comb begin
        addr = '0;
        if (fetch) begin
            addr = ADDR_W'(line) * ADDR_W'(STRIDE) + ADDR_W'(col);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_held <= 1'b0;
        end else begin
            bank_held <= bank;
        end
    end
endmodule

// File: rtl/idx_image_delay.sv
module idx_image_delay #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] tap [DEPTH+1];

    assign tap[0] = d;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                tap[s+1] <= '0;
            end else begin
                tap[s+1] <= tap[s];
            end
        end
    end

    assign q = tap[DEPTH];
endmodule

// File: rtl/idx_image_color_stage.sv
module idx_image_color_stage
    import idx_image_display_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vis,
    input  pal_code_e        code,
    input  logic             bank,
    input  logic [IDX_W-1:0] index,
    output rgb_t             color
);
    always_ff @(posedge clk) begin
        if (rst) begin
            color <= '0;
        end else if (vis) begin
            color <= pal_color(code, bank, index);
        end else begin
            color <= '0;
        end
    end
endmodule

// File: rtl/idx_image_display.sv
module idx_image_display
    import idx_image_display_pkg::*;
#(
    parameter int IMG_W  = 640,
    parameter int IMG_H  = 360,
    parameter int STRIDE = 640,
    parameter int ADDR_W = $clog2(IMG_W * IMG_H)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] line,
    input  logic               active,
    input  logic               hsync_in,
    input  logic               vsync_in,
    input  logic               img_sel,
    input  logic [1:0]         pal_sel,
    output logic               mem_en,
    output logic               mem_bank,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [IDX_W-1:0]   mem_rdata,
    output logic [CH_W-1:0]    red,
    output logic [CH_W-1:0]    green,
    output logic [CH_W-1:0]    blue,
    output logic               active_out,
    output logic               hsync_out,
    output logic               vsync_out
);
    localparam int LATENCY = 2;

    typedef struct packed {
        logic      vis;
        logic      bank;
        pal_code_e code;
    } fetch_tag_t;

    fetch_tag_t tag_q;
    rgb_t       color;
    logic [2:0] ctl_out;

    idx_image_addr_gen #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .STRIDE(STRIDE),
        .ADDR_W(ADDR_W)
    ) i_addr (
        .clk    (clk),
        .rst    (rst),
        .col    (col),
        .line   (line),
        .active (active),
        .img_sel(img_sel),
        .fetch  (mem_en),
        .bank   (mem_bank),
        .addr   (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q <= '{vis: mem_en, bank: mem_bank, code: pal_code_e'(pal_sel)};
        end
    end

    idx_image_color_stage i_color (
        .clk  (clk),
        .rst  (rst),
        .vis  (tag_q.vis),
        .code (tag_q.code),
        .bank (tag_q.bank),
        .index(mem_rdata),
        .color(color)
    );

    idx_image_delay #(
        .W    (3),
        .DEPTH(LATENCY)
    ) i_ctl (
        .clk(clk),
        .rst(rst),
        .d  ({active, hsync_in, vsync_in}),
        .q  (ctl_out)
    );

    assign {active_out, hsync_out, vsync_out} = ctl_out;
    assign red   = color.r;
    assign green = color.g;
    assign blue  = color.b;
endmodule

// File: rtl/idx_image_display_chk.sv
module idx_image_display_chk #(
    parameter int IMG_W  = 640,
    parameter int IMG_H  = 360,
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [9:0]        col,
    input logic [9:0]        line,
    input logic              active,
    input logic              hsync_in,
    input logic              vsync_in,
    input logic              mem_en,
    input logic              mem_bank,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        red,
    input logic [3:0]        green,
    input logic [3:0]        blue,
    input logic              active_out,
    input logic              hsync_out,
    input logic              vsync_out
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1: a fetch never addresses beyond the picture
    a_r1_addr_in_picture: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (int'(mem_addr) < IMG_W * IMG_H));

    // R2: no fetch below the picture
    a_r2_no_fetch_below: assert property (@(posedge clk) disable iff (rst)
        (int'(line) >= IMG_H) |-> !mem_en);

    // R3: blank outside active video
    a_r3_blank_colour: assert property (@(posedge clk) disable iff (rst)
        !active_out |-> (red == 4'd0 && green == 4'd0 && blue == 4'd0));

    // R4: control outputs trail inputs by two edges
    a_r4_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (active_out == $past(active, 2) &&
                                 hsync_out == $past(hsync_in, 2) &&
                                 vsync_out == $past(vsync_in, 2)));

    // R8: bank only moves at the frame origin
    a_r8_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && !(col == 10'd0 && line == 10'd0)) |-> $stable(mem_bank));
endmodule

bind idx_image_display idx_image_display_chk #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .ADDR_W(ADDR_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .col       (col),
    .line      (line),
    .active    (active),
    .hsync_in  (hsync_in),
    .vsync_in  (vsync_in),
    .mem_en    (mem_en),
    .mem_bank  (mem_bank),
    .mem_addr  (mem_addr),
    .red       (red),
    .green     (green),
    .blue      (blue),
    .active_out(active_out),
    .hsync_out (hsync_out),
    .vsync_out (vsync_out)
);

// File: tb/test_idx_image_display.sv
`timescale 1ns/1ps
module test_idx_image_display;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  col = '0;
    logic [9:0]  line = '0;
    logic        active = 1'b0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic        img_sel = 1'b0;
    logic [1:0]  pal_sel = 2'b00;
    logic        mem_en;
    logic        mem_bank;
    logic [17:0] mem_addr;
    logic [5:0]  mem_rdata = '0;
    logic [3:0]  red, green, blue;
    logic        active_out, hsync_out, vsync_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // expected pipeline entries: {active, hs, vs, rgb12}
    logic [14:0] q1 = '0;
    logic [14:0] q2 = '0;
    logic [1:0]  p1 = '0;
    logic [1:0]  p2 = '0;
    logic        bank_m = 1'b0;

    always #5 clk = ~clk;

    idx_image_display i_idx_image_display (
        .clk(clk), .rst(rst), .col(col), .line(line), .active(active),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .img_sel(img_sel),
        .pal_sel(pal_sel), .mem_en(mem_en), .mem_bank(mem_bank),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .red(red),
        .green(green), .blue(blue), .active_out(active_out),
        .hsync_out(hsync_out), .vsync_out(vsync_out)
    );

    function automatic logic [5:0] pic(input logic b, input int a);
        return 6'((a ^ (a >> 6) ^ (a >> 11)) + (b ? 29 : 0));
    endfunction

    always @(posedge clk) begin
        if (mem_en) mem_rdata <= pic(mem_bank, int'(mem_addr));
    end

    function automatic logic [3:0] dup(input logic [1:0] v);
        return {v, v};
    endfunction

    function automatic logic [11:0] expect_rgb(input logic [1:0] p, input logic b,
                                               input logic [5:0] i);
        logic [11:0] warm, cool;
        warm = {dup(i[5:4]), dup(i[3:2]), dup(i[1:0])};
        cool = {dup(i[1:0]), dup(i[3:2]), dup(i[5:4])};
        case (p)
            2'b00: return b ? cool : warm;
            2'b01: return warm;
            2'b10: return cool;
            default: return {i[5:2], i[5:2], i[5:2]};
        endcase
    endfunction

    function automatic string pal_req(input logic [1:0] p);
        case (p)
            2'b00: return "R5";
            2'b11: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int c, input int l, input logic a, input logic hs,
                        input logic vs, input logic is, input logic [1:0] ps);
        logic inimg;
        int addr;
        logic [11:0] rgb;
        @(negedge clk);
        // outputs now show the pixel driven two steps back (R4)
        chk("R4 active_out", int'(active_out), int'(q2[14]));
        chk("R4 hsync_out", int'(hsync_out), int'(q2[13]));
        chk("R4 vsync_out", int'(vsync_out), int'(q2[12]));
        if (!q2[14])
            chk("R3 blank", int'({red, green, blue}), int'(q2[11:0]));
        else
            chk({pal_req(p2), "/R2 colour"}, int'({red, green, blue}), int'(q2[11:0]));
        col = 10'(c); line = 10'(l); active = a; hsync_in = hs; vsync_in = vs;
        img_sel = is; pal_sel = ps;
        #1;
        if (c == 0 && l == 0) bank_m = is;
        inimg = a && l < 360 && c < 640;
        addr = l * 640 + c;
        chk("R1/R2 mem_en", int'(mem_en), int'(inimg));
        chk("R8 mem_bank", int'(mem_bank), int'(bank_m));
        if (inimg) chk("R1 mem_addr", int'(mem_addr), addr);
        rgb = inimg ? expect_rgb(ps, bank_m, pic(bank_m, addr)) : 12'd0;
        q2 = q1; p2 = p1;
        q1 = {a, hs, vs, rgb}; p1 = ps;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset colour", int'({red, green, blue}), 0);
        chk("R9 reset ctl", int'({active_out, hsync_out, vsync_out}), 0);
        chk("R9 reset bank", int'(mem_bank), 0);
        rst = 1'b0;
        // picture 0, every palette, frame origin
        step(0, 0, 1, 0, 1, 0, 2'b00);
        for (int k = 1; k < 12; k++) step(k * 53, 7, 1, k[0], 0, 1, 2'(k));
        // picture 1 chosen at origin, every palette
        step(0, 0, 1, 0, 0, 1, 2'b00);
        for (int k = 1; k < 12; k++) step(k * 41, 100, 1, 0, k[1], 0, 2'(k));
        // boundary lines and columns
        step(639, 359, 1, 0, 0, 0, 2'b00);
        step(0, 360, 1, 0, 0, 0, 2'b00);
        step(639, 360, 1, 1, 0, 0, 2'b11);
        step(0, 479, 1, 0, 1, 0, 2'b01);
        step(640, 10, 0, 1, 0, 0, 2'b00);
        step(5, 5, 0, 0, 0, 0, 2'b10);
        step(0, 359, 1, 0, 0, 0, 2'b10);
        // mid-frame change ignored, then origin takes it
        step(1, 0, 1, 0, 0, 0, 2'b00);
        step(2, 0, 1, 0, 0, 0, 2'b00);
        step(0, 0, 1, 0, 0, 0, 2'b00);
        step(1, 0, 1, 0, 0, 1, 2'b00);
        // random coordinates
        for (int n = 0; n < 4000; n++) begin
            int c, l;
            logic a;
            c = int'($urandom_range(0, 799));
            l = int'($urandom_range(0, 524));
            if ($urandom_range(0, 40) == 0) begin c = 0; l = 0; end
            a = (c < 640 && l < 480);
            if ($urandom_range(0, 9) == 0) a = 1'b0;
            step(c, l, a, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
        end
        step(0, 400, 0, 0, 0, 0, 2'b00);
        step(0, 400, 0, 0, 0, 0, 2'b00);
        step(0, 400, 0, 0, 0, 0, 2'b00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule